// File: doc/BRIEF.md
# DRAM Open-Page Hit Detector

This block classifies each external DRAM access as either a hit in the page that is currently open or a page fault that needs a full row cycle. It holds one record of the open page: the row part of the last completed access address, the bank it went to, and a valid flag. That single record is shared by every bank. The hit flag is combinational, so the sequencer can choose between a column-only cycle and a row-then-column cycle in the same clock that the request is presented. The record is loaded when the sequencer signals that an access has completed.

The column width can be set to 9, 10, 11 or 12 bits with a 2-bit size code. Only the address bits above the column field take part in the comparison. A page-logic enable can turn the detector off, and then every access is reported as a fault. When the bus is lost while the hold-on-loss control is clear, the open page is forgotten. When that control is set, the page survives the loss of the bus. A change of the size code or of the enable also forgets the open page.

Top module: `dram_page_hit`

## Requirements
- R1: The size code `page_size` sets the column width to 9 + code bits (00→9, 01→10, 10→11, 11→12). A hit needs address bits [23:9+code] to equal those of the tracked access, and the bits below that are ignored.
- R2: While `page_en` is 0, `in_page` is 0 for every request.
- R3: A request to a bank other than the bank of the last completed access is a page fault.
- R4: If `master_lost` is 1 and `hold_on_loss` is 0 at a clock edge, the record is invalidated and the next request is a page fault.
- R5: If `hold_on_loss` is 1, `master_lost` leaves the open page unchanged.
- R6: After reset the record is invalid, so the first request is a page fault.
- R7: A request presented with a value of `{page_en, page_size}` that differs from the value sampled at the previous edge is a fault, and such a change invalidates the record.
- R8: The record is loaded with the row and bank only at an edge where `acc_done` is 1. Requests without `acc_done` do not move it.
- R9: When `acc_done` and an invalidating `master_lost` fall on the same edge, invalidation wins and the next request is a page fault.
- R10: `in_page` is a combinational function of the current request inputs and the stored record. It has no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | 24 | Internal address of the request |
| req_bank | input | 2 | Bank-select code of the request |
| page_en | input | 1 | Enables open-page detection |
| page_size | input | 2 | Column-width code |
| hold_on_loss | input | 1 | Keeps the open page when the bus is lost |
| master_lost | input | 1 | Strobe: bus mastership lost |
| acc_done | input | 1 | Strobe: access completed, load the record |
| in_page | output | 1 | 1 = hit in the open page, 0 = page fault |

## Verification
A completed access (which loads the record) and a loss of the bus (which clears it) can occur on the same edge. The bench drives `acc_done` and `master_lost` together with `hold_on_loss` clear, after a hit has been set up. It then presents the same address on the following cycle and expects a fault, because invalidation takes priority. The same pairing with `hold_on_loss` set is also driven, and there the bench expects the page to remain open.

// File: rtl/dram_page_hit.sv
module dram_page_hit #(
  parameter int ADDR_W  = 24,
  parameter int BANK_W  = 2,
  parameter int MIN_COL = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              page_en,
  input  logic [1:0]        page_size,
  input  logic              hold_on_loss,
  input  logic              master_lost,
  input  logic              acc_done,
  output logic              in_page
);

  logic [ADDR_W-1:0] col_mask, row_key, row_q;
  logic [BANK_W-1:0] bank_q;
  logic [2:0]        cfg, cfg_q;
  logic              valid_q, drop;

  assign col_mask = ~({ADDR_W{1'b1}} << (MIN_COL + 32'(page_size)));
  assign row_key  = req_addr & ~col_mask;
  assign cfg      = {page_en, page_size};
  assign drop     = master_lost & ~hold_on_loss;

  assign in_page = page_en & valid_q & (cfg == cfg_q) &
                   (req_bank == bank_q) & (row_key == row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      row_q   <= '0;
      bank_q  <= '0;
      cfg_q   <= '0;
    end else begin
      cfg_q <= cfg;
      if (acc_done) begin
        row_q  <= row_key;
        bank_q <= req_bank;
      end
      if (drop)
        valid_q <= 1'b0;
      else if (acc_done)
        valid_q <= 1'b1;
      else if (cfg != cfg_q)
        valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_page_hit_chk.sv
module dram_page_hit_chk #(
  parameter int ADDR_W = 24,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BANK_W-1:0] req_bank,
  input logic              page_en,
  input logic [1:0]        page_size,
  input logic              hold_on_loss,
  input logic              master_lost,
  input logic              acc_done,
  input logic              in_page
);

  logic [BANK_W-1:0] seen_bank;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_bank <= '0;
    else if (acc_done) seen_bank <= req_bank;

  p_disabled_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !page_en |-> !in_page);

  p_bank_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_page |-> req_bank == seen_bank);

  p_loss_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_lost && !hold_on_loss) |=> !in_page);

  p_cfg_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({page_en, page_size}) |-> !in_page);

  p_loss_beats_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && master_lost && !hold_on_loss) |=> !in_page);

endmodule

bind dram_page_hit dram_page_hit_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/dram_page_hit_bench.sv
module dram_page_hit_bench;
  logic clk = 0, rst_n = 0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_bank = '0, page_size = '0;
  logic page_en = 0, hold_on_loss = 0, master_lost = 0, acc_done = 0;
  logic in_page;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dram_page_hit u_dram_page_hit (.*);

  // {addr, bank, size, en, hold, lost, done, expected in_page}
  localparam int NV = 30;
  localparam logic [32:0] VEC [NV] = '{
    {24'h000100, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 first access
    {24'h0001FF, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 same 9-bit page
    {24'h000200, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 next page
    {24'h000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 not moved
    {24'h000000, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 other bank
    {24'h000010, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 bank 1 open
    {24'h000010, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 bank 0 now
    {24'h000010, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 loss cycle
    {24'h000010, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 after loss
    {24'h000020, 2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 held
    {24'h000030, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 still open
    {24'h000030, 2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R9 held pairing
    {24'h000030, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R9 held pairing kept
    {24'h000030, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 size change
    {24'h0003FF, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 10-bit page
    {24'h000200, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 bit 9 ignored
    {24'h000400, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 bit 10 compared
    {24'h000000, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 size change
    {24'h000FFF, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 12-bit page
    {24'h001000, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 bit 12 compared
    {24'h000000, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 disabled
    {24'h000000, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 disabled stable
    {24'h000000, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 re-enable
    {24'h000000, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 open again
    {24'h000000, 2'd1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R9 pairing cycle
    {24'h000000, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 loss wins
    {24'h0007FF, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 size change
    {24'h000000, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 11-bit page
    {24'h000800, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 bit 11 compared
    {24'h800000, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R1 top bit compared
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (in_page !== exp) begin
      errors++;
      $display("FAIL %s in_page=%b expected %b", req, in_page, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog in_page=%b expected finish", in_page);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset", 1'b0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      {req_addr, req_bank, page_size, page_en, hold_on_loss, master_lost, acc_done} = VEC[i][32:1];
      #2;
      check($sformatf("vector %0d", i), VEC[i][0]);
      @(negedge clk);
    end
    // R10: hit follows the address within one cycle, no clock edge needed
    {hold_on_loss, master_lost, acc_done} = 3'b000;
    page_size = 2'd2; page_en = 1; req_bank = 2'd1; req_addr = 24'h000100;
    acc_done = 1;
    @(negedge clk);
    acc_done = 0; req_addr = 24'h000100;
    #1 check("R10 hit", 1'b1);
    req_addr = 24'h000900;
    #1 check("R10 comb miss", 1'b0);
    req_addr = 24'h0007F0;
    #1 check("R10 comb hit", 1'b1);
    // R6: reset in mid-run clears an open page
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    req_addr = 24'h000100;
    #1 check("R6 after reset", 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule